// File: doc/BRIEF.md
# Supply-Monitor Reset Controller

This block turns a digital supply-good comparator signal into a system reset. Software sees two byte-wide registers. The control register holds the monitor enable bit and a live read-only supply status bit. The source register holds the bit that arms the monitor as a reset source, plus a power-on flag. The comparator input passes through a two-flop synchroniser. A settling counter models the monitor's turn-on time after it is enabled.

The reset output is active low. It is held for a parameterised number of clocks after every cause has gone away. There are three causes: a supply fault seen by an enabled and armed monitor, arming the monitor before it has settled, and an external request from the other reset sources. Only the power-on input resets the enable bit. The external request does not change it.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and for `STRETCH_CYC` clocks after it rises, `rst_n` is low. After power-on the enable reads 1 (control bit 7), the power-on flag reads 1 (source bit 4) and the arm bit reads 0 (source bit 1).
- R2: A write to the control register (`wr_addr`=0) loads the enable from data bit 7. Data bits 5..0 are ignored, and control bits 5..0 read 0.
- R3: While enabled, control bit 6 shows the supply state: 1 above threshold (`supply_ok`=1), 0 at or below it. It lags the input by two clocks.
- R4: An external reset request (`ext_rst_req`) drives `rst_n` low and leaves the enable unchanged, whether it is 0 or 1.
- R5: With the enable and the arm bit both 1, a low supply drives `rst_n` low for as long as the supply stays low.
- R6: With the arm bit 0, or with the enable 0, a low supply causes no reset.
- R7: A source-register write (`wr_addr`=1) with data bit 1 set, made while the monitor is enabled but not yet settled, forces a reset.
- R8: The monitor counts as settled `SETTLE_CYC` clocks after the enable becomes 1. Arming it after that time causes no reset while the supply is good.
- R9: Writing 1 to source bit 4 clears the power-on flag. A reset caused by a supply fault does not set it again.
- R10: After the last clock with an active cause, `rst_n` stays low for `STRETCH_CYC` more clock edges and then goes high.
- R11: While the enable is 0, control bit 6 reads 1.
- R12: Writing the enable to 0 clears the settling count. Enabling again restarts the settling time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_req | input | 1 | Reset request from the other reset sources |
| supply_ok | input | 1 | Comparator output, asynchronous, 1 = supply above threshold |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = source register |
| wr_data | input | 8 | Write data |
| ctrl_rdata | output | 8 | Control register read value |
| src_rdata | output | 8 | Source register read value |
| rst_n | output | 1 | System reset, active low |

## Verification
The hardest case to reach is the early-arm reset. The arm write has to land inside the settling window, so the bench first disables the monitor and then enables it again. This restarts the count, and the arm write follows at once. After that the bench waits past `SETTLE_CYC` and arms again, which shows that the window has closed. Fault and release timing is sampled on exact clock counts, so that both the synchroniser delay and the stretch length are checked.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
    typedef struct packed {
        logic en;        // monitor enable
        logic arm;       // monitor selected as reset source
        logic por_flag;  // power-on seen
    } supmon_regs_t;
endpackage

// File: rtl/supmon_sync2.sv
module supmon_sync2 (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], din};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[1];
endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
    parameter int SETTLE_CYC = 20
) (
    input  logic clk,
    input  logic por_n,
    input  logic en,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)               cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign settled = en && (cnt_q == LAST);
endmodule

// File: rtl/supmon_stretch.sv
module supmon_stretch #(
    parameter int STRETCH_CYC = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause,
    output logic rst_n
);
    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          rst_n_d, rst_n_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cause)              cnt_d = LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        rst_n_d = (cnt_d == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q   <= LOAD;
            rst_n_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            rst_n_q <= rst_n_d;
        end
    end

    assign rst_n = rst_n_q;
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int SETTLE_CYC  = 20,
    parameter int STRETCH_CYC = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_req,
    input  logic       supply_ok,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] src_rdata,
    output logic       rst_n
);
    localparam int EN_BIT   = 7;
    localparam int STAT_BIT = 6;
    localparam int ARM_BIT  = 1;
    localparam int FLAG_BIT = 4;

    supmon_regs_t regs_d, regs_q;
    logic ok_sync, settled, early_arm, fault, cause;
    logic en_q, arm_q, status;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[6:5], wr_data[3:2], wr_data[0]};

    supmon_sync2 u_sync (
        .clk  (clk),
        .por_n(por_n),
        .din  (supply_ok),
        .dout (ok_sync)
    );

    supmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .por_n  (por_n),
        .en     (regs_q.en),
        .settled(settled)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en && !wr_addr) begin
            regs_d.en = wr_data[EN_BIT];
        end
        if (wr_en && wr_addr) begin
            regs_d.arm = wr_data[ARM_BIT];
            if (wr_data[FLAG_BIT]) regs_d.por_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            regs_q.en       <= 1'b1;
            regs_q.arm      <= 1'b0;
            regs_q.por_flag <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_q      = regs_q.en;
    assign arm_q     = regs_q.arm;
    assign status    = en_q ? ok_sync : 1'b1;
    assign early_arm = wr_en && wr_addr && wr_data[ARM_BIT] && en_q && !settled;
    assign fault     = en_q && arm_q && !ok_sync;
    assign cause     = ext_rst_req || fault || early_arm;

    supmon_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk  (clk),
        .por_n(por_n),
        .cause(cause),
        .rst_n(rst_n)
    );

    always_comb begin
        ctrl_rdata           = '0;
        ctrl_rdata[EN_BIT]   = en_q;
        ctrl_rdata[STAT_BIT] = status;
        src_rdata            = '0;
        src_rdata[ARM_BIT]   = arm_q;
        src_rdata[FLAG_BIT]  = regs_q.por_flag;
    end
endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
module supmon_rst_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_req,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] ctrl_rdata,
    input logic       rst_n,
    input logic       en_q,
    input logic       arm_q,
    input logic       ok_sync,
    input logic       settled,
    input logic       cause
);
    AST_FAULT_RESET: assert property (@(posedge clk) disable iff (!por_n)
        (en_q && arm_q && !ok_sync) |=> !rst_n); // R5

    AST_EARLY_ARM: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wr_addr && wr_data[1] && en_q && !settled) |=> !rst_n); // R7

    AST_OFF_STATUS: assert property (@(posedge clk) disable iff (!por_n)
        !ctrl_rdata[7] |-> ctrl_rdata[6]); // R11

    AST_EN_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst_req && !wr_en) |=> $stable(ctrl_rdata[7])); // R4

    AST_CLEAN_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> !$past(cause)); // R10
endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_req(ext_rst_req),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl_rdata (ctrl_rdata),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .arm_q      (arm_q),
    .ok_sync    (ok_sync),
    .settled    (settled),
    .cause      (cause)
);

// File: tb/supmon_rst_ctrl_test.sv
module supmon_rst_ctrl_test;
    localparam int SETTLE  = 20;
    localparam int STRETCH = 8;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       supply_ok = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ctrl_rdata, src_rdata;
    logic       rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supmon_rst_ctrl #(.SETTLE_CYC(SETTLE), .STRETCH_CYC(STRETCH)) uut (
        .clk(clk), .por_n(por_n), .ext_rst_req(ext_rst_req), .supply_ok(supply_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl_rdata(ctrl_rdata), .src_rdata(src_rdata), .rst_n(rst_n)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic addr, logic [7:0] data);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        step(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_power_on;
        por_n = 1'b0;
        step(3);
        check("R1 rst during por", 8'(rst_n), 8'h0);
        check("R1 enable", 8'(ctrl_rdata[7]), 8'h1);
        check("R1 por flag", 8'(src_rdata[4]), 8'h1);
        check("R1 arm", 8'(src_rdata[1]), 8'h0);
        por_n = 1'b1;
        step(STRETCH - 1);
        check("R1 still low", 8'(rst_n), 8'h0);
        step(1);
        check("R1 released", 8'(rst_n), 8'h1);
    endtask

    task automatic t_status_latency;
        supply_ok = 1'b0;
        step(1);
        check("R3 one flop", 8'(ctrl_rdata[6]), 8'h1);
        step(1);
        check("R3 low status", 8'(ctrl_rdata[6]), 8'h0);
        check("R6 no arm no reset", 8'(rst_n), 8'h1);
        step(4);
        check("R6 still no reset", 8'(rst_n), 8'h1);
        supply_ok = 1'b1;
        step(3);
        check("R3 high status", 8'(ctrl_rdata[6]), 8'h1);
    endtask

    task automatic t_arm_settled_and_fault;
        step(SETTLE + 2);
        write_reg(1'b1, 8'h12);
        step(2);
        check("R8 arm after settle", 8'(rst_n), 8'h1);
        check("R9 flag cleared", 8'(src_rdata[4]), 8'h0);
        supply_ok = 1'b0;
        step(3);
        check("R5 fault reset", 8'(rst_n), 8'h0);
        step(10);
        check("R5 held", 8'(rst_n), 8'h0);
        supply_ok = 1'b1;
        step(1 + STRETCH);
        check("R10 stretch low", 8'(rst_n), 8'h0);
        step(1);
        check("R10 release", 8'(rst_n), 8'h1);
        check("R9 flag not set by fault", 8'(src_rdata[4]), 8'h0);
    endtask

    task automatic t_disabled;
        write_reg(1'b0, 8'h00);
        step(1);
        check("R11 status when off", 8'(ctrl_rdata[6]), 8'h1);
        supply_ok = 1'b0;
        step(6);
        check("R6 disabled no reset", 8'(rst_n), 8'h1);
        check("R11 status off, supply low", 8'(ctrl_rdata[6]), 8'h1);
        supply_ok = 1'b1;
        step(4);
    endtask

    task automatic t_ext_reset;
        ext_rst_req = 1'b1;
        step(3);
        ext_rst_req = 1'b0;
        check("R4 ext reset asserts", 8'(rst_n), 8'h0);
        check("R4 enable stays 0", 8'(ctrl_rdata[7]), 8'h0);
        step(STRETCH + 2);
        check("R4 released", 8'(rst_n), 8'h1);
    endtask

    task automatic t_early_arm;
        write_reg(1'b0, 8'hBF);
        check("R2 enable written", 8'(ctrl_rdata[7]), 8'h1);
        check("R2 reserved ignored", 8'(ctrl_rdata[5:0]), 8'h00);
        write_reg(1'b1, 8'h02);
        check("R7 R12 early arm reset", 8'(rst_n), 8'h0);
        step(STRETCH + 2);
        check("R7 released", 8'(rst_n), 8'h1);
        step(SETTLE + 2);
        write_reg(1'b1, 8'h02);
        step(2);
        check("R8 settled arm no reset", 8'(rst_n), 8'h1);
        ext_rst_req = 1'b1;
        step(2);
        ext_rst_req = 1'b0;
        check("R4 enable stays 1", 8'(ctrl_rdata[7]), 8'h1);
        step(STRETCH + 2);
    endtask

    initial begin
        step(1);
        t_power_on();
        t_status_latency();
        t_arm_settled_and_fault();
        t_disabled();
        t_ext_reset();
        t_early_arm();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule